// File: doc/BRIEF.md
# Serial Master Register Front End

This block is the memory-mapped control and status front end of a two-wire serial master. Software reaches it over a simple 32-bit register port with a write strobe, a read strobe and a word address. It holds every setting the wire engine needs: clock configuration, device-mode setup, target register address, data word, command code, and the hardware and runtime device addresses. It also holds an interrupt enable mask, a sticky interrupt status register and a line-control register. The wire engine that shifts bits is a separate block. This front end launches it, can abort it or reset it, and records how each transfer finished.

Software loads the transfer registers and then sets the start bit. The start bit reads back as 1 while the engine is busy and clears itself when the engine reports completion. The completion result sets sticky status flags. Software clears those flags by writing ones to them. The single interrupt output is gated by a global enable and a per-flag enable mask. If software writes a transfer register while a transfer is running, the write is discarded and a load-busy flag is set. A soft-reset bit returns the block to idle within a fixed number of cycles. The line-control register lets software drive the clock and data lines directly for bit-banging, and it reports the synchronised levels of both lines.

Top module: `smst_csr`

## Requirements
- R1: After reset, every register reads 0, `irq`, `eng_start`, `eng_abort` and `eng_reset` are 0, and `scl_out`/`sda_out` follow `eng_scl`/`eng_sda`.
- R2: The registers sit at these offsets: 0x04 clock config (bits 10:0), 0x08 interrupt enable (bits 0, 1, 2, 11:8, 16), 0x10 register address (7:0), 0x1c data (31:0), 0x28 device mode (31:0), 0x2c command (7:0), 0x30 device address (runtime address in 23:16, hardware address in 15:0). Each reads back what was written, with bits outside its fields reading 0, and drives its `cfg_*` output.
- R3: Writing 1 to control bit 7 while idle pulses `eng_start` for exactly one cycle. Control bit 7 then reads 1 until `eng_done`.
- R4: On `eng_done` during a transfer, status bit 0 is set if `eng_err` is 0. If `eng_err` is 1, status bit 1 is set, `eng_data_err` is ORed into bits 11:8 and `eng_ack_err` into bit 16. If `eng_rdata_vld` is also high, the data register loads `eng_rdata`.
- R5: Writing the status register (0x0c) clears exactly the bits written as 1. A flag set in the same cycle as its clear stays set.
- R6: A write to 0x10, 0x1c, 0x2c or 0x30 while a transfer runs leaves that register unchanged and sets status bit 2. The same writes while idle leave bit 2 clear.
- R7: Writing 1 to control bit 6 during a transfer pulses `eng_abort`, clears control bit 7 and sets no status flag. While idle the same write has no effect.
- R8: `irq` is 1 one cycle after a state in which control bit 1 (global enable) is set and some status bit is set together with its enable bit. Otherwise it is 0.
- R9: Writing 1 to control bit 0 starts a soft reset. Bit 0 reads 1 and `eng_reset` is high for RST_CYC cycles, then both clear. The soft reset clears all status, ends any transfer and clears both line overrides.
- R10: In line control (0x24), bit 0 enables the data-line override and bit 1 gives its level; bit 2 enables the clock-line override and bit 3 gives its level. Bits 4 and 5 read the synchronised levels of `sda_in` and `scl_in`.
- R11: A start write while a transfer is already running produces no second `eng_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_reset | output | 1 | Engine reset, high during soft reset |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Transfer failed (valid with `eng_done`) |
| eng_ack_err | input | 1 | Acknowledge error (valid with `eng_done`) |
| eng_data_err | input | 4 | Per-byte data error mask (valid with `eng_done`) |
| eng_rdata_vld | input | 1 | Read data valid with `eng_done` |
| eng_rdata | input | DW | Read data from the engine |
| cfg_clk | output | 11 | Clock configuration field |
| cfg_devmode | output | 32 | Device-mode setup word |
| cfg_cmd | output | 8 | Command code |
| cfg_regaddr | output | 8 | Target register address |
| cfg_data | output | DW | Data word for writes |
| cfg_rtaddr | output | 8 | Runtime device address |
| cfg_hwaddr | output | 16 | Hardware device address |
| eng_scl | input | 1 | Clock-line level requested by the engine |
| eng_sda | input | 1 | Data-line level requested by the engine |
| scl_in | input | 1 | Live clock-line level |
| sda_in | input | 1 | Live data-line level |
| scl_out | output | 1 | Registered clock-line drive |
| sda_out | output | 1 | Registered data-line drive |

## Verification
The bench issues transfer-register writes in the middle of a transfer. A design that accepted them would show the new value on read-back, and one that failed to flag them would leave status bit 2 clear. It lands a completion pulse and a write-one-to-clear of the same flag on one clock edge; a design where the clear wins would lose the flag. It sends a second start and an abort both while idle and while busy, so a design without the busy qualifier would emit a spurious engine pulse. Soft reset is applied with flags, overrides and a transfer all active, and the bench checks that each returns to rest only after the fixed window.

// File: rtl/smst_pkg.sv
package smst_pkg;
  localparam int unsigned AW = 6;

  localparam logic [AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [AW-1:0] OFS_CLK   = 6'h04;
  localparam logic [AW-1:0] OFS_IE    = 6'h08;
  localparam logic [AW-1:0] OFS_STS   = 6'h0C;
  localparam logic [AW-1:0] OFS_RADDR = 6'h10;
  localparam logic [AW-1:0] OFS_DATA  = 6'h1C;
  localparam logic [AW-1:0] OFS_LINE  = 6'h24;
  localparam logic [AW-1:0] OFS_DMODE = 6'h28;
  localparam logic [AW-1:0] OFS_CMD   = 6'h2C;
  localparam logic [AW-1:0] OFS_DAR   = 6'h30;

  // control bit positions
  localparam int unsigned CTL_SRST  = 0;
  localparam int unsigned CTL_GIE   = 1;
  localparam int unsigned CTL_ABORT = 6;
  localparam int unsigned CTL_START = 7;

  // status bit positions
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_LBSY = 2;
  localparam int unsigned ST_DLO  = 8;
  localparam int unsigned DERR_W  = 4;
  localparam int unsigned ST_ACK  = 16;
  localparam int unsigned STS_W   = ST_ACK + 1;
  localparam logic [STS_W-1:0] STS_MASK = 17'h10F07;

  // field widths
  localparam int unsigned CLK_W  = 11;
  localparam int unsigned RA_W   = 8;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned RT_W   = 8;
  localparam int unsigned HW_W   = 16;
  localparam int unsigned DAR_W  = RT_W + HW_W;
  localparam int unsigned LINE_W = 4;

  typedef struct packed {
    logic                done;
    logic                err;
    logic                ack;
    logic [DERR_W-1:0]   derr;
  } eng_res_t;
endpackage

// File: rtl/smst_ctl.sv
module smst_ctl #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic req_start,
  input  logic req_abort,
  input  logic req_srst,
  input  logic eng_done,
  output logic busy,
  output logic rst_act,
  output logic eng_start,
  output logic eng_abort,
  output logic fin
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  assign fin = busy && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rst_act   <= 1'b0;
      eng_start <= 1'b0;
      eng_abort <= 1'b0;
      cnt       <= '0;
    end else begin
      eng_start <= 1'b0;
      eng_abort <= 1'b0;
      if (rst_act) begin
        if (cnt == CNT_LAST) begin
          rst_act <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (ctrl_wr && req_srst) begin
        rst_act <= 1'b1;
        cnt     <= '0;
        busy    <= 1'b0;
      end else if (busy) begin
        if (eng_done) begin
          busy <= 1'b0;
        end else if (ctrl_wr && req_abort) begin
          busy      <= 1'b0;
          eng_abort <= 1'b1;
        end
      end else if (ctrl_wr && req_start) begin
        busy      <= 1'b1;
        eng_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smst_sts.sv
module smst_sts
  import smst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             fin,
  input  eng_res_t         res,
  input  logic             lbsy_set,
  input  logic             w1c_en,
  input  logic [STS_W-1:0] w1c_mask,
  input  logic [STS_W-1:0] ie,
  input  logic             gie,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic [STS_W-1:0] set_v;
  logic [STS_W-1:0] clr_v;

  always_comb begin
    set_v = '0;
    if (fin) begin
      if (res.err) begin
        set_v[ST_ERR]                  = 1'b1;
        set_v[ST_DLO +: DERR_W]        = res.derr;
        set_v[ST_ACK]                  = res.ack;
      end else begin
        set_v[ST_DONE] = 1'b1;
      end
    end
    if (lbsy_set) set_v[ST_LBSY] = 1'b1;
    clr_v = w1c_en ? w1c_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      if (clr_all) sts <= '0;
      else         sts <= ((sts & ~clr_v) | set_v) & STS_MASK;
      irq <= gie && (|(sts & ie));
    end
  end
endmodule

// File: rtl/smst_line.sv
module smst_line
  import smst_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              release_i,
  input  logic              ovr_wr,
  input  logic [LINE_W-1:0] ovr_wdata,
  input  logic              eng_scl,
  input  logic              eng_sda,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic [LINE_W-1:0] ovr,
  output logic              scl_out,
  output logic              sda_out,
  output logic              lvl_scl,
  output logic              lvl_sda
);
  logic [SYNC_N-1:0] sync_scl;
  logic [SYNC_N-1:0] sync_sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr      <= '0;
      scl_out  <= 1'b1;
      sda_out  <= 1'b1;
      sync_scl <= '1;
      sync_sda <= '1;
    end else begin
      if (release_i)   ovr <= '0;
      else if (ovr_wr) ovr <= ovr_wdata;
      sda_out  <= ovr[0] ? ovr[1] : eng_sda;
      scl_out  <= ovr[2] ? ovr[3] : eng_scl;
      sync_scl <= {sync_scl[SYNC_N-2:0], scl_in};
      sync_sda <= {sync_sda[SYNC_N-2:0], sda_in};
    end
  end

  assign lvl_scl = sync_scl[SYNC_N-1];
  assign lvl_sda = sync_sda[SYNC_N-1];
endmodule

// File: rtl/smst_csr.sv
module smst_csr
  import smst_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned RST_CYC = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_abort,
  output logic              eng_reset,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_ack_err,
  input  logic [DERR_W-1:0] eng_data_err,
  input  logic              eng_rdata_vld,
  input  logic [DW-1:0]     eng_rdata,
  output logic [CLK_W-1:0]  cfg_clk,
  output logic [31:0]       cfg_devmode,
  output logic [CMD_W-1:0]  cfg_cmd,
  output logic [RA_W-1:0]   cfg_regaddr,
  output logic [DW-1:0]     cfg_data,
  output logic [RT_W-1:0]   cfg_rtaddr,
  output logic [HW_W-1:0]   cfg_hwaddr,
  input  logic              eng_scl,
  input  logic              eng_sda,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_out,
  output logic              sda_out
);
  logic busy, rst_act, fin, gie_q;
  logic [STS_W-1:0]  sts, ie_q;
  logic [CLK_W-1:0]  clk_q;
  logic [31:0]       dmode_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [RA_W-1:0]   raddr_q;
  logic [DW-1:0]     data_q;
  logic [DAR_W-1:0]  dar_q;
  logic [LINE_W-1:0] ovr;
  logic              lvl_scl, lvl_sda;
  logic [DW-1:0]     rd_mux;
  eng_res_t          res;

  logic wr_ctrl, wr_clk, wr_ie, wr_sts, wr_raddr, wr_data;
  logic wr_line, wr_dmode, wr_cmd, wr_dar, lock_hit;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_clk   = bus_wr && (bus_addr == OFS_CLK);
  assign wr_ie    = bus_wr && (bus_addr == OFS_IE);
  assign wr_sts   = bus_wr && (bus_addr == OFS_STS);
  assign wr_raddr = bus_wr && (bus_addr == OFS_RADDR);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_line  = bus_wr && (bus_addr == OFS_LINE);
  assign wr_dmode = bus_wr && (bus_addr == OFS_DMODE);
  assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
  assign wr_dar   = bus_wr && (bus_addr == OFS_DAR);
  assign lock_hit = busy && (wr_raddr || wr_data || wr_cmd || wr_dar);

  assign res.done = eng_done;
  assign res.err  = eng_err;
  assign res.ack  = eng_ack_err;
  assign res.derr = eng_data_err;

  smst_ctl #(.RST_CYC(RST_CYC)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_ctrl),
    .req_start (bus_wdata[CTL_START]),
    .req_abort (bus_wdata[CTL_ABORT]),
    .req_srst  (bus_wdata[CTL_SRST]),
    .eng_done  (eng_done),
    .busy      (busy),
    .rst_act   (rst_act),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .fin       (fin)
  );

  smst_sts u_sts (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (rst_act),
    .fin      (fin),
    .res      (res),
    .lbsy_set (lock_hit),
    .w1c_en   (wr_sts),
    .w1c_mask (bus_wdata[STS_W-1:0]),
    .ie       (ie_q),
    .gie      (gie_q),
    .sts      (sts),
    .irq      (irq)
  );

  smst_line #(.SYNC_N(SYNC_N)) u_line (
    .clk       (clk),
    .rst       (rst),
    .release_i (rst_act),
    .ovr_wr    (wr_line),
    .ovr_wdata (bus_wdata[LINE_W-1:0]),
    .eng_scl   (eng_scl),
    .eng_sda   (eng_sda),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .ovr       (ovr),
    .scl_out   (scl_out),
    .sda_out   (sda_out),
    .lvl_scl   (lvl_scl),
    .lvl_sda   (lvl_sda)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      clk_q   <= '0;
      ie_q    <= '0;
      dmode_q <= '0;
      cmd_q   <= '0;
      raddr_q <= '0;
      data_q  <= '0;
      dar_q   <= '0;
    end else begin
      if (wr_ctrl)  gie_q   <= bus_wdata[CTL_GIE];
      if (wr_clk)   clk_q   <= bus_wdata[CLK_W-1:0];
      if (wr_ie)    ie_q    <= bus_wdata[STS_W-1:0] & STS_MASK;
      if (wr_dmode) dmode_q <= bus_wdata[31:0];
      if (!busy) begin
        if (wr_cmd)   cmd_q   <= bus_wdata[CMD_W-1:0];
        if (wr_raddr) raddr_q <= bus_wdata[RA_W-1:0];
        if (wr_dar)   dar_q   <= bus_wdata[DAR_W-1:0];
      end
      if (fin && eng_rdata_vld)    data_q <= eng_rdata;
      else if (wr_data && !busy)   data_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        rd_mux[CTL_START] = busy;
        rd_mux[CTL_GIE]   = gie_q;
        rd_mux[CTL_SRST]  = rst_act;
      end
      OFS_CLK:   rd_mux[CLK_W-1:0]  = clk_q;
      OFS_IE:    rd_mux[STS_W-1:0]  = ie_q;
      OFS_STS:   rd_mux[STS_W-1:0]  = sts;
      OFS_RADDR: rd_mux[RA_W-1:0]   = raddr_q;
      OFS_DATA:  rd_mux             = data_q;
      OFS_LINE:  rd_mux[LINE_W+1:0] = {lvl_scl, lvl_sda, ovr};
      OFS_DMODE: rd_mux[31:0]       = dmode_q;
      OFS_CMD:   rd_mux[CMD_W-1:0]  = cmd_q;
      OFS_DAR:   rd_mux[DAR_W-1:0]  = dar_q;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign eng_reset   = rst_act;
  assign cfg_clk     = clk_q;
  assign cfg_devmode = dmode_q;
  assign cfg_cmd     = cmd_q;
  assign cfg_regaddr = raddr_q;
  assign cfg_data    = data_q;
  assign cfg_rtaddr  = dar_q[DAR_W-1:HW_W];
  assign cfg_hwaddr  = dar_q[HW_W-1:0];
endmodule

// File: rtl/smst_csr_chk.sv
module smst_csr_chk
  import smst_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             rst_act,
  input logic             eng_start,
  input logic             eng_abort,
  input logic             eng_done,
  input logic             eng_err,
  input logic             gie,
  input logic             irq,
  input logic [STS_W-1:0] sts,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       cfg_cmd
);
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> (!eng_start && (busy || rst_act || !$past(busy))));

  assert_abort_ends_R7: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> !busy);

  assert_cmd_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == OFS_CMD) |=> $stable(cfg_cmd));

  assert_done_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done && !eng_err && !rst_act) |=> sts[ST_DONE]);

  assert_srst_clear_R9: assert property (@(posedge clk) disable iff (rst)
    rst_act |=> (sts == '0 && !busy));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(gie) |-> !irq);
endmodule

bind smst_csr smst_csr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .rst_act   (rst_act),
  .eng_start (eng_start),
  .eng_abort (eng_abort),
  .eng_done  (eng_done),
  .eng_err   (eng_err),
  .gie       (gie_q),
  .irq       (irq),
  .sts       (sts),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cfg_cmd   (cfg_cmd)
);

// File: tb/smst_csr_tb.sv
`timescale 1ns/1ps
module smst_csr_tb;
  import smst_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, eng_start, eng_abort, eng_reset;
  logic eng_done = 0, eng_err = 0, eng_ack_err = 0, eng_rdata_vld = 0;
  logic [3:0]  eng_data_err = '0;
  logic [31:0] eng_rdata = '0;
  logic [10:0] cfg_clk;
  logic [31:0] cfg_devmode, cfg_data;
  logic [7:0]  cfg_cmd, cfg_regaddr, cfg_rtaddr;
  logic [15:0] cfg_hwaddr;
  logic eng_scl = 1, eng_sda = 1, scl_in = 1, sda_in = 1;
  logic scl_out, sda_out;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  smst_csr u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_reset(eng_reset),
    .eng_done(eng_done), .eng_err(eng_err), .eng_ack_err(eng_ack_err),
    .eng_data_err(eng_data_err), .eng_rdata_vld(eng_rdata_vld), .eng_rdata(eng_rdata),
    .cfg_clk(cfg_clk), .cfg_devmode(cfg_devmode), .cfg_cmd(cfg_cmd),
    .cfg_regaddr(cfg_regaddr), .cfg_data(cfg_data), .cfg_rtaddr(cfg_rtaddr),
    .cfg_hwaddr(cfg_hwaddr), .eng_scl(eng_scl), .eng_sda(eng_sda),
    .scl_in(scl_in), .sda_in(sda_in), .scl_out(scl_out), .sda_out(sda_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic done(input logic err, input logic ack, input logic [3:0] derr,
                      input logic vld, input logic [31:0] d);
    @(negedge clk);
    eng_done = 1; eng_err = err; eng_ack_err = ack; eng_data_err = derr;
    eng_rdata_vld = vld; eng_rdata = d;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_ack_err = 0; eng_data_err = '0; eng_rdata_vld = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 eng pulses", {29'b0, eng_start, eng_abort, eng_reset}, 0);
    check("R1 lines", {30'b0, scl_out, sda_out}, 32'h3);
    rd(OFS_CTRL, v); check("R1 ctrl", v, 0);
    rd(OFS_STS, v);  check("R1 status", v, 0);
    rd(OFS_DAR, v);  check("R1 dar", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(OFS_CLK, 32'hFFFF_FFFF);   rd(OFS_CLK, v);   check("R2 clk", v, 32'h7FF);
    check("R2 cfg_clk", {21'b0, cfg_clk}, 32'h7FF);
    wr(OFS_IE, 32'hFFFF_FFFF);    rd(OFS_IE, v);    check("R2 ie", v, 32'h10F07);
    wr(OFS_RADDR, 32'h1A5);       rd(OFS_RADDR, v); check("R2 raddr", v, 32'hA5);
    wr(OFS_DATA, 32'hDEADBEEF);   rd(OFS_DATA, v);  check("R2 data", v, 32'hDEADBEEF);
    wr(OFS_DMODE, 32'h807C3E00);  rd(OFS_DMODE, v); check("R2 dmode", v, 32'h807C3E00);
    wr(OFS_CMD, 32'h18B);         rd(OFS_CMD, v);   check("R2 cmd", v, 32'h8B);
    wr(OFS_DAR, 32'hFF2D03A3);    rd(OFS_DAR, v);   check("R2 dar", v, 32'h2D03A3);
    check("R2 hwaddr", {16'b0, cfg_hwaddr}, 32'h3A3);
    check("R2 rtaddr", {24'b0, cfg_rtaddr}, 32'h2D);
  endtask

  task automatic t_start_done();
    logic [31:0] v;
    wr(OFS_CTRL, 32'h80);
    check("R3 start pulse", {31'b0, eng_start}, 1);
    @(negedge clk); check("R3 pulse one cycle", {31'b0, eng_start}, 0);
    rd(OFS_CTRL, v); check("R3 busy bit", v, 32'h80);
    wr(OFS_CTRL, 32'h80);
    check("R11 no restart", {31'b0, eng_start}, 0);
    done(0, 0, 0, 0, 0);
    rd(OFS_CTRL, v); check("R3 busy clears", v, 0);
    rd(OFS_STS, v);  check("R4 done flag", v, 32'h1);
    wr(OFS_STS, 32'h1); rd(OFS_STS, v); check("R5 w1c", v, 0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    wr(OFS_CTRL, 32'h80);
    done(1, 1, 4'hA, 0, 0);
    rd(OFS_STS, v); check("R4 error flags", v, 32'h10A02);
    wr(OFS_STS, 32'h200); rd(OFS_STS, v); check("R5 partial clear", v, 32'h10802);
    wr(OFS_STS, 32'h10F07); rd(OFS_STS, v); check("R5 full clear", v, 0);
  endtask

  task automatic t_read_data();
    logic [31:0] v;
    wr(OFS_CTRL, 32'h80);
    done(0, 0, 0, 1, 32'h12345678);
    rd(OFS_DATA, v); check("R4 read data", v, 32'h12345678);
    wr(OFS_STS, 32'h1);
  endtask

  task automatic t_lbsy();
    logic [31:0] v;
    wr(OFS_CMD, 32'h4E);
    rd(OFS_STS, v); check("R6 idle write no flag", v, 0);
    wr(OFS_CTRL, 32'h80);
    wr(OFS_CMD, 32'h59);
    wr(OFS_DATA, 32'h1);
    wr(OFS_RADDR, 32'h3);
    wr(OFS_DAR, 32'h1);
    wr(OFS_CLK, 32'h15);
    rd(OFS_CMD, v);   check("R6 cmd kept", v, 32'h4E);
    rd(OFS_DATA, v);  check("R6 data kept", v, 32'h12345678);
    rd(OFS_RADDR, v); check("R6 raddr kept", v, 32'hA5);
    rd(OFS_DAR, v);   check("R6 dar kept", v, 32'h2D03A3);
    rd(OFS_CLK, v);   check("R2 clk writable busy", v, 32'h15);
    rd(OFS_STS, v);   check("R6 load busy flag", v, 32'h4);
    done(0, 0, 0, 0, 0);
    rd(OFS_STS, v);   check("R6 flags after done", v, 32'h5);
    wr(OFS_STS, 32'h7);
  endtask

  task automatic t_set_vs_clr();
    logic [31:0] v;
    wr(OFS_CTRL, 32'h80);
    @(negedge clk);
    eng_done = 1; bus_wr = 1; bus_addr = OFS_STS; bus_wdata = 32'h1;
    @(negedge clk);
    eng_done = 0; bus_wr = 0;
    rd(OFS_STS, v); check("R5 set beats clear", v, 32'h1);
    wr(OFS_STS, 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(OFS_CTRL, 32'h40);
    check("R7 idle abort ignored", {31'b0, eng_abort}, 0);
    wr(OFS_CTRL, 32'h80);
    wr(OFS_CTRL, 32'h40);
    check("R7 abort pulse", {31'b0, eng_abort}, 1);
    rd(OFS_CTRL, v); check("R7 busy cleared", v, 0);
    rd(OFS_STS, v);  check("R7 no status", v, 0);
  endtask

  task automatic t_irq();
    wr(OFS_IE, 32'h1);
    wr(OFS_CTRL, 32'h80);
    done(0, 0, 0, 0, 0);
    @(negedge clk); check("R8 gie off", {31'b0, irq}, 0);
    wr(OFS_CTRL, 32'h02);
    @(negedge clk); check("R8 irq raised", {31'b0, irq}, 1);
    wr(OFS_IE, 32'h2);
    @(negedge clk); check("R8 masked", {31'b0, irq}, 0);
    wr(OFS_IE, 32'h1);
    @(negedge clk); check("R8 unmasked", {31'b0, irq}, 1);
    wr(OFS_STS, 32'h1);
    @(negedge clk); check("R8 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(OFS_LINE, 32'h5);
    @(negedge clk);
    check("R10 both forced low", {30'b0, scl_out, sda_out}, 0);
    wr(OFS_CTRL, 32'h80);
    wr(OFS_CMD, 32'h63);
    wr(OFS_CTRL, 32'h01);
    check("R9 engine reset", {31'b0, eng_reset}, 1);
    rd(OFS_CTRL, v); check("R9 bit0 busy", v, 32'h1);
    repeat (6) @(negedge clk);
    check("R9 engine reset ends", {31'b0, eng_reset}, 0);
    rd(OFS_CTRL, v); check("R9 idle", v, 0);
    rd(OFS_STS, v);  check("R9 status cleared", v, 0);
    rd(OFS_LINE, v); check("R9 overrides released", v, 32'h30);
    check("R9 lines released", {30'b0, scl_out, sda_out}, 32'h3);
  endtask

  task automatic t_line();
    logic [31:0] v;
    wr(OFS_LINE, 32'h3);
    eng_sda = 0; eng_scl = 0;
    repeat (2) @(negedge clk);
    check("R10 sda forced high", {31'b0, sda_out}, 1);
    check("R10 scl follows engine", {31'b0, scl_out}, 0);
    eng_scl = 1; eng_sda = 1;
    wr(OFS_LINE, 32'h4);
    @(negedge clk);
    check("R10 scl forced low", {30'b0, scl_out, sda_out}, 32'h1);
    sda_in = 1; scl_in = 0;
    repeat (4) @(negedge clk);
    rd(OFS_LINE, v); check("R10 levels a", v, 32'h14);
    sda_in = 0; scl_in = 1;
    repeat (4) @(negedge clk);
    rd(OFS_LINE, v); check("R10 levels b", v, 32'h24);
    wr(OFS_LINE, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_start_done();
    t_err();
    t_read_data();
    t_lbsy();
    t_set_vs_clr();
    t_abort();
    t_irq();
    t_srst();
    t_line();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog R1 actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule